// File: doc/BRIEF.md
# FIFO Threshold Trigger Generator

This block sits next to the transmit and receive queues of a serial peripheral and turns their fill levels into two request lines. One line asks for more transmit data, the other asks for received data to be collected. Interrupt logic and a DMA engine can both use these lines. Each direction has a 2-bit selector that picks the occupancy at which its request fires. Transmit can fire while the queue is not full, once half the space is free, or only when the queue is empty. Receive can fire on any data, at half full, or only when full.

The queue storage is not part of the block. Only the fill counts come in. A global enable turns queueing on or off. When queueing is off, each direction acts as a single holding register and the selectors have no effect. Both requests are registered, so they follow the inputs one clock later.

Top module: `fifo_trig_gen`

## Requirements
- R1: While `rst_n` is low, `tx_req` and `rx_req` are 0.
- R2: Each request is registered. A change on any input shows on the outputs only after the next rising clock edge.
- R3: With queueing on and `tx_sel` = 0, `tx_req` is 1 exactly when `tx_level` < DEPTH.
- R4: With queueing on and `tx_sel` = 1, `tx_req` is 1 exactly when DEPTH − `tx_level` ≥ DEPTH/2.
- R5: With queueing on and `tx_sel` = 2, `tx_req` is 1 exactly when `tx_level` = 0.
- R6: With queueing on and `rx_sel` = 0, `rx_req` is 1 exactly when `rx_level` ≥ 1.
- R7: With queueing on and `rx_sel` = 1, `rx_req` is 1 exactly when `rx_level` ≥ DEPTH/2.
- R8: With queueing on and `rx_sel` = 2, `rx_req` is 1 exactly when `rx_level` = DEPTH.
- R9: A selector value of 3 is reserved. It behaves exactly like value 0 in both directions.
- R10: With `fifo_on` = 0, `tx_req` = (`tx_level` = 0) and `rx_req` = (`rx_level` ≠ 0), whatever the values of `tx_sel` and `rx_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_on | input | 1 | 1 = queue mode, 0 = single holding register |
| tx_sel | input | 2 | Transmit threshold: 0 not full, 1 half free, 2 empty, 3 reserved (same as 0) |
| rx_sel | input | 2 | Receive threshold: 0 non-empty, 1 half full, 2 full, 3 reserved (same as 0) |
| tx_level | input | $clog2(DEPTH)+1 | Entries held in the transmit queue |
| rx_level | input | $clog2(DEPTH)+1 | Entries held in the receive queue |
| tx_req | output | 1 | Transmit-data request |
| rx_req | output | 1 | Receive-data request |

## Verification
The bench builds the block with DEPTH = 8, so the half point is 4 entries. Every threshold boundary can be reached with 4-bit levels. Levels of 3, 4 and 5 sit on both sides of the half point in each direction, and levels of 7 and 8 sit on both sides of full. In the disabled mode, levels of 0 and 1 show whether the selectors are truly ignored.

// File: rtl/fifo_trig_gen.sv
module fifo_trig_gen #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_on,
  input  logic [1:0]                 tx_sel,
  input  logic [1:0]                 rx_sel,
  input  logic [$clog2(DEPTH):0]     tx_level,
  input  logic [$clog2(DEPTH):0]     rx_level,
  output logic                       tx_req,
  output logic                       rx_req
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0] tx_free;
  logic          tx_hit, rx_hit;

  assign tx_free = FULL - tx_level;

  always_comb begin
    if (!fifo_on) begin
      tx_hit = (tx_level == '0);
      rx_hit = (rx_level != '0);
    end else begin
      unique case (tx_sel)
        2'd1:    tx_hit = (tx_free >= HALF);
        2'd2:    tx_hit = (tx_level == '0);
        default: tx_hit = (tx_level < FULL);
      endcase
      unique case (rx_sel)
        2'd1:    rx_hit = (rx_level >= HALF);
        2'd2:    rx_hit = (rx_level == FULL);
        default: rx_hit = (rx_level != '0);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      tx_req <= tx_hit;
      rx_req <= rx_hit;
    end
  end

  // R3
  tx_full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && tx_level == FULL) |=> !tx_req);

  // R5
  tx_empty_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |=> tx_req);

  // R6
  rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> !rx_req);

  // R8
  rx_full_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && rx_level == FULL) |=> rx_req);

  // R10
  single_reg_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && rx_level != '0) |=> rx_req);

endmodule

// File: tb/fifo_trig_gen_bench.sv
module fifo_trig_gen_bench;
  localparam int D  = 8;
  localparam int LW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_on = 1'b0;
  logic [1:0] tx_sel = '0, rx_sel = '0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic tx_req, rx_req;
  int n_run = 0, n_bad = 0;

  always #4 clk = ~clk;

  fifo_trig_gen #(.DEPTH(D)) u_fifo_trig_gen (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .tx_level(tx_level), .rx_level(rx_level), .tx_req(tx_req), .rx_req(rx_req));

  // {fifo_on, tx_sel, rx_sel, tx_level, rx_level, exp_tx, exp_rx}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd0, 4'd0, 4'd0, 1'b1, 1'b0},  // R3 R6
    {1'b1, 2'd0, 2'd0, 4'd7, 4'd1, 1'b1, 1'b1},  // R3 R6
    {1'b1, 2'd0, 2'd0, 4'd8, 4'd8, 1'b0, 1'b1},  // R3 R6
    {1'b1, 2'd1, 2'd1, 4'd4, 4'd4, 1'b1, 1'b1},  // R4 R7
    {1'b1, 2'd1, 2'd1, 4'd5, 4'd3, 1'b0, 1'b0},  // R4 R7
    {1'b1, 2'd1, 2'd2, 4'd3, 4'd7, 1'b1, 1'b0},  // R4 R8
    {1'b1, 2'd2, 2'd2, 4'd0, 4'd8, 1'b1, 1'b1},  // R5 R8
    {1'b1, 2'd2, 2'd2, 4'd1, 4'd7, 1'b0, 1'b0},  // R5 R8
    {1'b1, 2'd2, 2'd1, 4'd0, 4'd0, 1'b1, 1'b0},  // R5 R7
    {1'b1, 2'd3, 2'd3, 4'd7, 4'd1, 1'b1, 1'b1},  // R9
    {1'b1, 2'd3, 2'd3, 4'd8, 4'd0, 1'b0, 1'b0},  // R9
    {1'b0, 2'd2, 2'd2, 4'd0, 4'd1, 1'b1, 1'b1},  // R10
    {1'b0, 2'd1, 2'd1, 4'd1, 4'd0, 1'b0, 1'b0},  // R10
    {1'b0, 2'd0, 2'd0, 4'd1, 4'd1, 1'b0, 1'b1}   // R10
  };

  task automatic check(input logic got, input logic exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    tx_level = '0; rx_level = 4'd3; fifo_on = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_req, 1'b0, "R1 tx");
    check(rx_req, 1'b0, "R1 rx");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {fifo_on, tx_sel, rx_sel, tx_level, rx_level} = VEC[i][14:2];
      @(negedge clk);
      check(tx_req, VEC[i][1], $sformatf("vec %0d tx (R3 R4 R5 R9 R10)", i));
      check(rx_req, VEC[i][0], $sformatf("vec %0d rx (R6 R7 R8 R9 R10)", i));
    end

    // R2: outputs hold until the next rising edge
    @(negedge clk);
    fifo_on = 1'b1; tx_sel = 2'd0; rx_sel = 2'd0; tx_level = 4'd2; rx_level = 4'd0;
    @(negedge clk);
    check(tx_req, 1'b1, "R2 setup tx");
    tx_level = 4'd8; rx_level = 4'd5;
    #1;
    check(tx_req, 1'b1, "R2 tx held");
    check(rx_req, 1'b0, "R2 rx held");
    @(negedge clk);
    check(tx_req, 1'b0, "R2 tx updated");
    check(rx_req, 1'b1, "R2 rx updated");

    // R10: disabled mode ignores a full-level threshold
    fifo_on = 1'b0; tx_sel = 2'd1; rx_sel = 2'd2; tx_level = 4'd0; rx_level = 4'd1;
    @(negedge clk);
    check(tx_req, 1'b1, "R10 tx sel ignored");
    check(rx_req, 1'b1, "R10 rx sel ignored");

    // R1: reset applied mid-run
    rst_n = 1'b0;
    #1;
    check(tx_req, 1'b0, "R1 mid-run tx");
    check(rx_req, 1'b0, "R1 mid-run rx");
    @(negedge clk);
    check(rx_req, 1'b0, "R1 held in reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule